// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block sits in front of a processor interrupt controller and turns four raw external interrupt request pins into four qualified request lines for a downstream priority encoder. Each pin is first brought into the clock domain through a short flop chain. It is then interpreted according to a per-line sense type: a high level, a low level, a rising edge or a falling edge. Edge events are captured in a per-line latch that software clears explicitly. A per-line enable and a global master enable gate the result.

All configuration sits in one 32-bit control word, reached through a plain single-cycle register port. A write updates the word on the clock edge on which the write strobe is sampled, and reads are combinational. Software acknowledges an edge-captured request by writing a one to that line's clear bit in the same word. A single stored routing bit for critical-class requests is also held in the word and presented on its own output.

Top module: `irq_pin_conditioner`

## Requirements
- R1: After reset the control word reads 0, so all enables, sense fields, the master enable and the routing bit are 0. All request outputs are 0 and all latches are clear.
- R2: The control word stores the following bits and reads them back, while every other bit reads 0:
  - bits 23:16, the sense fields;
  - bit 12, the master enable;
  - bits 11:8, the line enables;
  - bit 0, the critical routing bit.
  A write with all ones therefore reads back as 0x00FF1F01, and with no write the word does not change.
- R3: Sense code 0 makes line n request while its pin is high. The sense field of line n is bits [23-2n:22-2n]. A pin change reaches the request output on the third rising clock edge after it is applied.
- R4: Sense code 3 makes line n request while its pin is low.
- R5: Sense code 1 latches a rising edge on the pin. The request stays active after the pin returns low, until the line is cleared.
- R6: Sense code 2 latches a falling edge on the pin. The request stays active after the pin returns high, until the line is cleared.
- R7: Writing 1 to bit 27-n clears the latch of line n in the same cycle as the write. The clear bits always read as 0.
- R8: When a clear write to a line coincides with a newly detected edge on that line, the latch stays set.
- R9: Line n is enabled by bit 11-n. A disabled line never requests, but an edge seen while it is disabled is still latched. That latched edge appears on the output once the line is enabled.
- R10: While master enable bit 12 is 0, no request output is active, whatever the pins and latches hold.
- R11: In the level modes, the clear bit has no effect on the request.
- R12: The critical routing output equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regWrData | input | 32 | Control word write data |
| regRdData | output | 32 | Control word read data |
| irqPins | input | 4 | Raw external interrupt request pins |
| irqReq | output | 4 | Qualified request per line |
| critRoute | output | 1 | Critical request routing select |

## Verification
The assertions assume the register port only changes the control word on a cycle with the write strobe high. The edge-hold property assumes the control word can only clear a latch through such a write, so it is checked only on cycles without a write. The stimulus drives the write strobe and the pins on the falling clock edge. Every write lasts one cycle, and pins are held for at least four cycles between changes, so each synchronised transition is seen exactly once. All four sense codes are swept on every line, with the other lines kept disabled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINE_CNT = 4;
  localparam int REG_W    = 32;
  // bit positions of the control word fields (line n counts down from the top)
  localparam int CLR_TOP   = 27;
  localparam int SENSE_TOP = 23;
  localparam int MASTER_B  = 12;
  localparam int EN_TOP    = 11;
  localparam int CRIT_B    = 0;

  typedef enum logic [1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_RISE   = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_LVL_LO = 2'd3
  } sense_e;

  typedef struct packed {
    logic                         master;
    logic [LINE_CNT-1:0]          lineEn;
    logic [LINE_CNT-1:0]          clrLine;
    logic [LINE_CNT-1:0][1:0]     senseSel;
  } ctrl_strobe_t;

  function automatic logic [REG_W-1:0] storeMask();
    logic [REG_W-1:0] m;
    m = '0;
    m[MASTER_B] = 1'b1;
    m[CRIT_B]   = 1'b1;
    for (int n = 0; n < LINE_CNT; n++) begin
      m[EN_TOP-n]          = 1'b1;
      m[SENSE_TOP-2*n]     = 1'b1;
      m[SENSE_TOP-2*n-1]   = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             critRoute,
  output ctrl_strobe_t     strb
);
  localparam logic [REG_W-1:0] KEEP_MASK = storeMask();

  logic [REG_W-1:0] ctrlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (wrEn) begin
      ctrlQ <= wrData & KEEP_MASK;
    end
  end

  assign rdData    = ctrlQ;
  assign critRoute = ctrlQ[CRIT_B];

  always_comb begin
    strb.master = ctrlQ[MASTER_B];
    for (int n = 0; n < LINE_CNT; n++) begin
      strb.lineEn[n]   = ctrlQ[EN_TOP-n];
      strb.clrLine[n]  = wrEn & wrData[CLR_TOP-n];
      strb.senseSel[n] = ctrlQ[SENSE_TOP-2*n -: 2];
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LINE_CNT-1:0] pins,
  input  ctrl_strobe_t        strb,
  output logic [LINE_CNT-1:0] req
);
  localparam int LAST = SYNC_DEPTH - 1;

  for (genvar n = 0; n < LINE_CNT; n++) begin : g_line
    logic [SYNC_DEPTH-1:0] syncQ;
    logic                  prevQ;
    logic                  latchQ;
    logic                  cur;
    logic                  edgeHit;
    logic                  latchNext;
    sense_e                mode;

    assign cur  = syncQ[LAST];
    assign mode = sense_e'(strb.senseSel[n]);

    always_comb begin
      edgeHit   = 1'b0;
      latchNext = latchQ;
      unique case (mode)
        SENSE_LVL_HI: latchNext = cur;
        SENSE_LVL_LO: latchNext = ~cur;
        SENSE_RISE: begin
          edgeHit   = cur & ~prevQ;
          latchNext = (latchQ & ~strb.clrLine[n]) | edgeHit;
        end
        SENSE_FALL: begin
          edgeHit   = ~cur & prevQ;
          latchNext = (latchQ & ~strb.clrLine[n]) | edgeHit;
        end
        default: latchNext = latchQ;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= '0;
        prevQ  <= 1'b0;
        latchQ <= 1'b0;
      end else begin
        if (SYNC_DEPTH > 1) syncQ <= {syncQ[SYNC_DEPTH-2:0], pins[n]};
        else                syncQ <= pins[n];
        prevQ  <= cur;
        latchQ <= latchNext;
      end
    end

    assign req[n] = strb.master & strb.lineEn[n] & latchQ;
  end
endmodule

// File: rtl/irq_pin_conditioner.sv
module irq_pin_conditioner
  import irqc_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [3:0]  irqPins,
  output logic [3:0]  irqReq,
  output logic        critRoute
);
  ctrl_strobe_t strb;

  irqc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .critRoute(critRoute),
    .strb     (strb)
  );

  irqc_datapath #(.SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk (clk),
    .rstN(rstN),
    .pins(irqPins),
    .strb(strb),
    .req (irqReq)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [31:0] regRdData,
  input logic [3:0]  irqReq,
  input logic        critRoute
);
  // R10: master enable low forbids every request
  assert_master_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[12] |-> (irqReq == 4'b0));

  // R7: clear bits never read back as set
  assert_clr_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[27:24] == 4'b0);

  // R2: control word only moves on a write
  assert_ctrl_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(regRdData));

  // R12: routing output mirrors bit 0
  assert_crit_route_R12: assert property (@(posedge clk) disable iff (!rstN)
    critRoute == regRdData[0]);

  for (genvar n = 0; n < 4; n++) begin : g_chk
    // R9: disabled line never requests
    assert_line_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
      !regRdData[11-n] |-> !irqReq[n]);

    // R5: an edge-mode request holds while no write touches the word
    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (irqReq[n] && !regWrEn && (regRdData[23-2*n -: 2] inside {2'd1, 2'd2}))
      |=> irqReq[n]);
  end
endmodule

bind irq_pin_conditioner irqc_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regRdData(regRdData),
  .irqReq   (irqReq),
  .critRoute(critRoute)
);

// File: tb/test_irq_pin_conditioner.sv
module test_irq_pin_conditioner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  irqPins = '0;
  logic [3:0]  irqReq;
  logic        critRoute;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_pin_conditioner i_irq_pin_conditioner (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqPins(irqPins), .irqReq(irqReq), .critRoute(critRoute)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [31:0] d);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [31:0] base;
    logic        lat, prevPin, expBit;
    logic [4:0]  seq;

    waitCyc(2);
    // R1: reset state
    check("R1 rd", regRdData, 32'h0);
    check("R1 req", {28'h0, irqReq}, 32'h0);
    rstN = 1'b1;
    waitCyc(2);
    check("R1 req after release", {28'h0, irqReq}, 32'h0);

    // R2: layout readback
    writeReg(32'hFFFF_FFFF);
    check("R2 all ones", regRdData, 32'h00FF_1F01);
    waitCyc(3);
    check("R2 no-write hold", regRdData, 32'h00FF_1F01);
    writeReg(32'h0);
    check("R2 zero", regRdData, 32'h0);

    // R12: routing bit
    writeReg(32'h1);
    check("R12 set", {31'h0, critRoute}, 32'h1);
    writeReg(32'h0);
    check("R12 clear", {31'h0, critRoute}, 32'h0);

    // R3..R7, R11 sweep: every line, every sense code
    seq = 5'b10110; // pin values applied in order (bit 0 first)
    for (int n = 0; n < 4; n++) begin
      for (int mode = 0; mode < 4; mode++) begin
        base = (32'h1 << 12) | (32'h1 << (11 - n)) | (32'(mode) << (22 - 2*n));
        irqPins = '0;
        writeReg(32'h0);
        waitCyc(4);
        writeReg(base | (32'h1 << (27 - n)));
        lat = 1'b0;
        prevPin = 1'b0;
        for (int s = 0; s < 5; s++) begin
          irqPins[n] = seq[s];
          waitCyc(4);
          if (mode == 1 && !prevPin && seq[s]) lat = 1'b1;
          if (mode == 2 && prevPin && !seq[s]) lat = 1'b1;
          prevPin = seq[s];
          expBit = (mode == 0) ? seq[s] : (mode == 3) ? ~seq[s] : lat;
          check((mode == 0) ? "R3 level-high" : (mode == 3) ? "R4 level-low" :
                (mode == 1) ? "R5 rising" : "R6 falling",
                {28'h0, irqReq}, 32'(expBit) << n);
          // clear after every step
          writeReg(base | (32'h1 << (27 - n)));
          if (mode == 1 || mode == 2) lat = 1'b0;
          expBit = (mode == 0) ? seq[s] : (mode == 3) ? ~seq[s] : lat;
          check((mode == 0 || mode == 3) ? "R11 level clear ignored" : "R7 clear",
                {28'h0, irqReq}, 32'(expBit) << n);
          check("R7 clear reads 0", {28'h0, regRdData[27:24]}, 32'h0);
        end
      end
    end

    // R3 latency: third rising edge
    irqPins = '0;
    writeReg((32'h1 << 12) | (32'h1 << 8));
    waitCyc(4);
    irqPins[3] = 1'b1;
    waitCyc(2);
    check("R3 not before third edge", {28'h0, irqReq}, 32'h0);
    waitCyc(1);
    check("R3 on third edge", {28'h0, irqReq}, 32'h8);

    // R10: master enable gates
    irqPins = 4'b0001;
    writeReg(32'h1 << 11);
    waitCyc(4);
    check("R10 master off", {28'h0, irqReq}, 32'h0);
    writeReg((32'h1 << 11) | (32'h1 << 12));
    check("R10 master on", {28'h0, irqReq}, 32'h1);
    writeReg(32'h1 << 11);
    check("R10 master off again", {28'h0, irqReq}, 32'h0);

    // R9: edge captured while line disabled
    irqPins = '0;
    base = (32'h1 << 12) | (32'h1 << 20);
    writeReg(base | (32'h1 << 26));
    waitCyc(4);
    irqPins[1] = 1'b1;
    waitCyc(4);
    check("R9 disabled", {28'h0, irqReq}, 32'h0);
    writeReg(base | (32'h1 << 10));
    check("R9 enabled shows latched edge", {28'h0, irqReq}, 32'h2);

    // R8: clear coinciding with edge detection
    irqPins = '0;
    base = (32'h1 << 12) | (32'h1 << 9) | (32'h1 << 18);
    writeReg(base | (32'h1 << 25));
    waitCyc(4);
    check("R8 start clear", {28'h0, irqReq}, 32'h0);
    irqPins[2] = 1'b1;
    waitCyc(2);
    writeReg(base | (32'h1 << 25));
    check("R8 edge wins over clear", {28'h0, irqReq}, 32'h4);
    writeReg(base | (32'h1 << 25));
    check("R8 later clear works", {28'h0, irqReq}, 32'h0);

    finished = 1'b1;
    summary();
  end
endmodule